// File: doc/BRIEF.md
# Scripted Power Sequencer

This block runs short power-transition scripts that are stored in a small on-chip instruction memory. Each instruction takes four bytes. Together they give a 16-bit resource-control message, a delay and the index of the instruction that follows. The instructions therefore form a linked chain. When a transition request arrives, the engine looks up that transition's start pointer. It then fetches the instruction bytes one per cycle and emits the message with a one-cycle strobe. Next it waits the programmed number of slow timebase ticks and follows the link. It stops when the link holds the reserved terminator index.

A host programs the block through a byte-wide write port. To load the instruction memory, the host first writes a byte address into an address register and then writes the byte itself into a data register. There are four start-pointer registers, one for each transition kind: entry to sleep, wake-up of groups 1 and 2, wake-up of group 3, and warm reset. Writing the terminator index into a start pointer disables that transition. The message bus that carries the messages to the resources lies outside the block.

Top module: `pwr_script_seq`

## Requirements
- R1: After reset, `busy` and `msg_valid` are low and all four start pointers hold the terminator 0x3F, so no trigger runs a script until a pointer is written.
- R2: A write with `host_sel`=0 loads the memory byte address. A write with `host_sel`=1 stores `host_wdata` at that address. Instruction i occupies byte addresses 4i to 4i+3 in the order message high byte, message low byte, delay, next index. Indices 0 to 0x3E are all usable, including 0x3E.
- R3: For each executed instruction, `msg_valid` is high for exactly one cycle and `msg` equals {high byte, low byte} in that cycle. `busy` is high whenever `msg_valid` is high.
- R4: After an instruction, execution continues at its next index. It ends when the next index is 0x3F, after which `busy` falls and no further strobe appears.
- R5: After an instruction's strobe, the next fetch begins only once `slow_tick` has been sampled high on as many cycles as the delay byte holds. A delay of 0 proceeds without any tick, and no ticks means the engine waits indefinitely.
- R6: A trigger whose selected start pointer is 0x3F produces no strobe, and `busy` stays low.
- R7: Writes with `host_sel` 2, 3, 4 and 5 set the start pointers for sleep entry, group 3 wake-up, group 1/2 wake-up and warm reset. Each trigger starts at its own pointer.
- R8: When triggers coincide, the engine selects warm reset first, then group 1/2 wake-up, then group 3 wake-up, then sleep entry. The selected one is used even if its pointer is disabled, in which case nothing runs.
- R9: Triggers that arrive while `busy` is high are ignored. They neither restart nor queue a script.
- R10: A trigger sampled while idle raises `busy` at that edge. The first strobe appears 5 clock edges after the sampling edge of the trigger, counting that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Host register select (0 address, 1 data, 2..5 start pointers) |
| host_wdata | input | 8 | Host write data |
| trig_sleep | input | 1 | Request for the sleep-entry transition |
| trig_wake3 | input | 1 | Request for the group 3 wake-up transition |
| trig_wake12 | input | 1 | Request for the group 1/2 wake-up transition |
| trig_warm | input | 1 | Request for the warm-reset transition |
| slow_tick | input | 1 | One-cycle enable from the slow timebase that counts delays |
| busy | output | 1 | High while a script runs |
| msg_valid | output | 1 | One-cycle strobe for each issued message |
| msg | output | 16 | Resource-control message |

## Verification
The embedded assertions check, on every cycle, the following properties. The strobe lasts a single cycle and only appears while busy. A waiting engine holds its countdown unless a tick arrives, and never leaves the wait early. The fetch pointer stays put during a fetch regardless of incoming triggers. A disabled warm-reset pointer never starts a run. A start-pointer write lands in the addressed register. Other properties need directed scenarios. These are: the byte layout of an instruction, how the chain is walked and where it ends, the exact latency from trigger to first strobe, and the number of ticks consumed per delay. The scenarios also cover the priority among coincident triggers, the use of the last usable index, and the fact that triggers raised mid-run leave no trace.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int BYTE_W        = 8;
    localparam int BYTES_PER_INS = 4;
    localparam int BCNT_W        = $clog2(BYTES_PER_INS);
    localparam int MSG_W         = 2 * BYTE_W;
    localparam int N_TRANS       = 4;
    localparam int SEL_W         = 3;

    // host register select codes
    localparam logic [SEL_W-1:0] SEL_MADDR    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MDATA    = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PTR_BASE = 3'd2;

    // transition index; higher index wins when triggers coincide
    typedef enum logic [1:0] {
        TR_SLEEP  = 2'd0,
        TR_WAKE3  = 2'd1,
        TR_WAKE12 = 2'd2,
        TR_WARM   = 2'd3
    } trans_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/seq_host_regs.sv
module seq_host_regs
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_we,
    input  logic [SEL_W-1:0]                host_sel,
    input  logic [BYTE_W-1:0]               host_wdata,
    output logic                            mem_we,
    output logic [IDX_W+BCNT_W-1:0]         mem_waddr,
    output logic [BYTE_W-1:0]               mem_wdata,
    output logic [N_TRANS-1:0][IDX_W-1:0]   ptr
);
    localparam int ADDR_W = IDX_W + BCNT_W;
    localparam logic [IDX_W-1:0] END_IDX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0]                maddr;
        logic [N_TRANS-1:0][IDX_W-1:0]    ptr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (host_we) begin
            if (host_sel == SEL_MADDR) begin
                regs_d.maddr = ADDR_W'(host_wdata);
            end
            for (int k = 0; k < N_TRANS; k++) begin
                if (host_sel == SEL_PTR_BASE + SEL_W'(k)) begin
                    regs_d.ptr[k] = IDX_W'(host_wdata);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.maddr <= '0;
            for (int k = 0; k < N_TRANS; k++) begin
                regs_q.ptr[k] <= END_IDX;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_we    = host_we && (host_sel == SEL_MDATA);
    assign mem_waddr = regs_q.maddr;
    assign mem_wdata = host_wdata;
    assign ptr       = regs_q.ptr;

    // R7
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == SEL_PTR_BASE + SEL_W'(TR_WARM))
        |=> ptr[TR_WARM] == $past(host_wdata[IDX_W-1:0]));
endmodule

// File: rtl/seq_script_mem.sv
module seq_script_mem
    import pwr_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/seq_engine.sv
module seq_engine
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_TRANS-1:0]              trig,
    input  logic [N_TRANS-1:0][IDX_W-1:0]   ptr,
    input  logic                            tick,
    input  logic [BYTE_W-1:0]               rd_data,
    output logic [IDX_W+BCNT_W-1:0]         rd_addr,
    output logic                            busy,
    output logic                            msg_valid,
    output logic [MSG_W-1:0]                msg
);
    localparam logic [IDX_W-1:0]  END_IDX  = '1;
    localparam logic [BCNT_W-1:0] LAST_B   = BCNT_W'(BYTES_PER_INS - 1);
    localparam int                TSEL_W   = $clog2(N_TRANS);

    typedef struct packed {
        eng_state_e         st;
        logic [IDX_W-1:0]   pc;
        logic [BCNT_W-1:0]  bcnt;
        logic [BYTE_W-1:0]  hi;
        logic [BYTE_W-1:0]  lo;
        logic [BYTE_W-1:0]  dly;
        logic [IDX_W-1:0]   nxt;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [TSEL_W-1:0] tsel;

    always_comb begin
        eng_d = eng_q;
        tsel  = '0;
        for (int k = 0; k < N_TRANS; k++) begin
            if (trig[k]) begin
                tsel = TSEL_W'(k);
            end
        end
        case (eng_q.st)
            ST_IDLE: begin
                if (|trig && ptr[tsel] != END_IDX) begin
                    eng_d.st   = ST_FETCH;
                    eng_d.pc   = ptr[tsel];
                    eng_d.bcnt = '0;
                end
            end
            ST_FETCH: begin
                case (eng_q.bcnt)
                    2'd0:    eng_d.hi  = rd_data;
                    2'd1:    eng_d.lo  = rd_data;
                    2'd2:    eng_d.dly = rd_data;
                    default: eng_d.nxt = IDX_W'(rd_data);
                endcase
                eng_d.bcnt = eng_q.bcnt + 1'b1;
                if (eng_q.bcnt == LAST_B) begin
                    eng_d.st = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                eng_d.st = ST_WAIT;
            end
            default: begin
                if (eng_q.dly == '0) begin
                    if (eng_q.nxt == END_IDX) begin
                        eng_d.st = ST_IDLE;
                    end else begin
                        eng_d.st   = ST_FETCH;
                        eng_d.pc   = eng_q.nxt;
                        eng_d.bcnt = '0;
                    end
                end else if (tick) begin
                    eng_d.dly = eng_q.dly - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, pc: '0, bcnt: '0, hi: '0, lo: '0, dly: '0, nxt: END_IDX};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rd_addr   = {eng_q.pc, eng_q.bcnt};
    assign busy      = (eng_q.st != ST_IDLE);
    assign msg_valid = (eng_q.st == ST_ISSUE);
    assign msg       = {eng_q.hi, eng_q.lo};

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    // R3
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> busy);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WAIT && eng_q.dly != '0 && !tick)
        |=> (eng_q.st == ST_WAIT && $stable(eng_q.dly)));

    // R5
    wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WAIT && eng_q.dly != '0) |=> eng_q.st == ST_WAIT);

    // R9
    fetch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_FETCH && eng_q.bcnt != '0) |-> $stable(eng_q.pc));
endmodule

// File: rtl/pwr_script_seq.sv
module pwr_script_seq
    import pwr_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [7:0]        host_wdata,
    input  logic              trig_sleep,
    input  logic              trig_wake3,
    input  logic              trig_wake12,
    input  logic              trig_warm,
    input  logic              slow_tick,
    output logic              busy,
    output logic              msg_valid,
    output logic [15:0]       msg
);
    localparam int ADDR_W = IDX_W + BCNT_W;
    localparam logic [IDX_W-1:0] END_IDX = '1;

    logic                           mem_we;
    logic [ADDR_W-1:0]              mem_waddr;
    logic [BYTE_W-1:0]              mem_wdata;
    logic [ADDR_W-1:0]              rd_addr;
    logic [BYTE_W-1:0]              rd_data;
    logic [N_TRANS-1:0][IDX_W-1:0]  ptr;
    logic [N_TRANS-1:0]             trig_vec;

    assign trig_vec = {trig_warm, trig_wake12, trig_wake3, trig_sleep};

    seq_host_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .ptr        (ptr)
    );

    seq_script_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    seq_engine #(.IDX_W(IDX_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_vec),
        .ptr       (ptr),
        .tick      (slow_tick),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .msg_valid (msg_valid),
        .msg       (msg)
    );

    // R6
    warm_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_warm && ptr[TR_WARM] == END_IDX) |=> !busy);
endmodule

// File: tb/pwr_script_seq_test.sv
`timescale 1ns/1ps
module pwr_script_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic        trig_sleep = 1'b0, trig_wake3 = 1'b0, trig_wake12 = 1'b0, trig_warm = 1'b0;
    logic        slow_tick = 1'b0;
    logic        busy, msg_valid;
    logic [15:0] msg;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int nlog = 0;
    logic [15:0] log_msg [64];
    int log_cyc [64];
    int trig_cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_script_seq uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .trig_sleep(trig_sleep), .trig_wake3(trig_wake3),
        .trig_wake12(trig_wake12), .trig_warm(trig_warm), .slow_tick(slow_tick),
        .busy(busy), .msg_valid(msg_valid), .msg(msg)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (msg_valid && nlog < 64) begin
            log_msg[nlog] = msg;
            log_cyc[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic host_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic load_ins(input int idx, input logic [15:0] m, input logic [7:0] dly, input logic [7:0] nx);
        logic [7:0] b [4];
        b[0] = m[15:8]; b[1] = m[7:0]; b[2] = dly; b[3] = nx;
        for (int k = 0; k < 4; k++) begin
            host_write(3'd0, 8'(idx * 4 + k));
            host_write(3'd1, b[k]);
        end
    endtask

    // trig bits: {warm, wake12, wake3, sleep}
    task automatic pulse(input logic [3:0] t);
        @(negedge clk);
        {trig_warm, trig_wake12, trig_wake3, trig_sleep} = t;
        trig_cyc = cyc;
        @(negedge clk);
        {trig_warm, trig_wake12, trig_wake3, trig_sleep} = '0;
    endtask

    task automatic run_until_idle(input string req);
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            slow_tick = 1'b1;
            n++;
        end
        @(negedge clk);
        slow_tick = 1'b0;
        chk(!busy, req, "run completes", busy, 0);
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        int base;
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(msg_valid == 1'b0, "R1", "strobe after reset", msg_valid, 0);
        base = nlog;
        pulse(4'b1111);
        chk(busy == 1'b0, "R1", "busy with reset pointers", busy, 0);
        pulse(4'b0001);
        idle_cycles(10);
        chk(nlog == base, "R1", "strobes with reset pointers", nlog - base, 0);
    endtask

    task automatic t_chain();
        int base;
        load_ins(0, 16'h1234, 8'd0, 8'd5);
        load_ins(5, 16'hABCD, 8'd1, 8'd2);
        load_ins(2, 16'h0F0F, 8'd0, 8'h3F);
        host_write(3'd4, 8'd0);
        base = nlog;
        pulse(4'b0100);
        chk(busy == 1'b1, "R10", "busy after trigger edge", busy, 1);
        run_until_idle("R4");
        chk(nlog - base == 3, "R4", "chain length", nlog - base, 3);
        chk(log_msg[base] == 16'h1234, "R2", "first message", log_msg[base], 16'h1234);
        chk(log_msg[base+1] == 16'hABCD, "R4", "linked message", log_msg[base+1], 16'hABCD);
        chk(log_msg[base+2] == 16'h0F0F, "R4", "last message", log_msg[base+2], 16'h0F0F);
        chk(log_cyc[base] - trig_cyc == 5, "R10", "trigger to first strobe", log_cyc[base] - trig_cyc, 5);
        chk(log_cyc[base+1] - log_cyc[base] > 1, "R3", "strobe not stretched", log_cyc[base+1] - log_cyc[base], 2);
        idle_cycles(10);
        chk(nlog - base == 3, "R4", "no strobe after end", nlog - base, 3);
    endtask

    task automatic t_each_pointer();
        logic [15:0] exp [4];
        int base;
        exp[0] = 16'hA5A0; exp[1] = 16'hC3C3; exp[2] = 16'h1212; exp[3] = 16'h7E7E;
        for (int k = 0; k < 4; k++) begin
            load_ins(10 + k, exp[k], 8'd0, 8'h3F);
            host_write(3'(2 + k), 8'(10 + k));
        end
        for (int k = 0; k < 4; k++) begin
            base = nlog;
            pulse(4'(1 << k));
            idle_cycles(10);
            chk(busy == 1'b0, "R5", "zero delay ends without ticks", busy, 0);
            chk(nlog - base == 1, "R7", "one strobe per pointer", nlog - base, 1);
            chk(log_msg[base] == exp[k], "R7", "message from own pointer", log_msg[base], exp[k]);
        end
    endtask

    task automatic t_last_index();
        int base;
        load_ins(62, 16'hBEEF, 8'd0, 8'h3F);
        host_write(3'd2, 8'd62);
        base = nlog;
        pulse(4'b0001);
        run_until_idle("R2");
        chk(nlog - base == 1 && log_msg[base] == 16'hBEEF, "R2", "index 0x3E runs", log_msg[base], 16'hBEEF);
        host_write(3'd2, 8'd10);
    endtask

    task automatic t_delay();
        int base;
        load_ins(30, 16'h3030, 8'd3, 8'd31);
        load_ins(31, 16'h3131, 8'd0, 8'h3F);
        host_write(3'd3, 8'd30);
        base = nlog;
        pulse(4'b0010);
        idle_cycles(6);
        chk(nlog - base == 1, "R5", "first strobe before wait", nlog - base, 1);
        idle_cycles(20);
        chk(busy == 1'b1 && nlog - base == 1, "R5", "stalled without ticks", nlog - base, 1);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
        idle_cycles(10);
        chk(nlog - base == 1, "R5", "two of three ticks", nlog - base, 1);
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        idle_cycles(8);
        chk(nlog - base == 2, "R5", "third tick releases", nlog - base, 2);
        chk(log_msg[base+1] == 16'h3131, "R5", "message after wait", log_msg[base+1], 16'h3131);
        chk(busy == 1'b0, "R4", "idle after chain", busy, 0);
        host_write(3'd3, 8'd11);
    endtask

    task automatic t_busy_ignore();
        int base;
        load_ins(20, 16'h5555, 8'd2, 8'd21);
        load_ins(21, 16'h6666, 8'd0, 8'h3F);
        host_write(3'd2, 8'd20);
        base = nlog;
        pulse(4'b0001);
        idle_cycles(8);
        pulse(4'b1000);
        pulse(4'b0110);
        chk(busy == 1'b1 && nlog - base == 1, "R9", "still on first run", nlog - base, 1);
        run_until_idle("R9");
        idle_cycles(12);
        chk(nlog - base == 2, "R9", "mid-run triggers dropped", nlog - base, 2);
        chk(log_msg[base] == 16'h5555 && log_msg[base+1] == 16'h6666, "R9", "own messages only",
            log_msg[base+1], 16'h6666);
        host_write(3'd2, 8'd10);
    endtask

    task automatic t_priority();
        int base;
        base = nlog;
        pulse(4'b1111);
        run_until_idle("R8");
        chk(log_msg[base] == 16'h7E7E, "R8", "warm wins", log_msg[base], 16'h7E7E);
        base = nlog;
        pulse(4'b0111);
        run_until_idle("R8");
        chk(log_msg[base] == 16'h1212, "R8", "group 1/2 wake next", log_msg[base], 16'h1212);
        base = nlog;
        pulse(4'b0011);
        run_until_idle("R8");
        chk(log_msg[base] == 16'hC3C3, "R8", "group 3 over sleep", log_msg[base], 16'hC3C3);
        host_write(3'd5, 8'h3F);
        base = nlog;
        pulse(4'b1000);
        chk(busy == 1'b0, "R6", "disabled pointer stays idle", busy, 0);
        pulse(4'b1001);
        idle_cycles(10);
        chk(nlog == base, "R8", "disabled winner runs nothing", nlog - base, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_chain();
        t_each_pointer();
        t_last_index();
        t_delay();
        t_busy_ignore();
        t_priority();
        done = 1;
        summary();
        $finish;
    end
endmodule